// File: doc/BRIEF.md
# Floating-Point Exception Status Word

This block keeps the exception portion of a floating-point status word. An execution unit reports events to it every cycle: a raw vector of exception bits, a C1 qualifier, dedicated strobes for precision loss (rounded up or rounded down), a denormal-operand strobe and stack overflow/underflow strobes. The block merges these into sticky flags. It keeps the error-summary and busy bits in step with the control-word masks, and it updates the overloaded C1 condition bit.

The only thing it reports back is `unmasked_o`. That output tells the surrounding pipeline, in the same cycle, that an event it just raised is not masked and must be handled as a trap. Trap delivery, the arithmetic and the register stack are outside this block. A synchronous clear returns the whole word to zero.

Top module: `fpu_exc_status`

## Requirements
- R1: Only bits 6:0 of `raise_i` are taken as events. Bits 15:7 of `raise_i` have no effect on the status word or on `unmasked_o`.
- R2: Flag layout is IE=0, DE=1, ZE=2, OE=3, UE=4, PE=5, SF=6. A raised flag appears in `status_o` on the next clock edge and stays set until a clear or a reset.
- R3: Bit 7 (error summary) and bit 15 (busy) become set on the edge after any flag in bits 5:0 is set while the matching `mask_i` bit is 0. The mask bit order matches the flag order, IE at mask bit 0. Both bits stay set until a clear and always hold equal values.
- R4: `unmasked_o` is combinational. It is 1 in the same cycle when an event raised in that cycle has its mask bit clear. Flags that were already set do not drive it.
- R5: When SF or PE is raised in a cycle, C1 (bit 9) is set if a C1 qualifier is present and cleared otherwise. In any other cycle C1 holds its value.
- R6: `prec_up_i` sets PE and sets C1. When PE is masked it sets neither bit 7 nor `unmasked_o`.
- R7: `prec_dn_i` sets PE and clears C1.
- R8: When DE is masked, `denorm_i` sets only DE. When DE is unmasked it also drives `unmasked_o` and sets the summary and busy bits.
- R9: `stk_over_i` sets IE, SF and C1=1. `stk_under_i` sets IE, SF and C1=0.
- R10: `clr_i` zeroes the whole status word on the next edge and takes priority over any event in the same cycle.
- R11: After reset `status_o` is zero. Bits 8 and 14:10 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_i | input | 1 | Synchronous clear of the status word |
| raise_i | input | 16 | Raw exception bits; only 6:0 are used |
| mask_i | input | 6 | Control-word mask bits, 1 = masked |
| c1_qual_i | input | 1 | C1 qualifier for raw SF/PE events |
| prec_up_i | input | 1 | Precision loss, rounded up |
| prec_dn_i | input | 1 | Precision loss, rounded down |
| denorm_i | input | 1 | Denormal operand seen |
| stk_over_i | input | 1 | Register stack overflow |
| stk_under_i | input | 1 | Register stack underflow |
| status_o | output | 16 | Status word |
| unmasked_o | output | 1 | A newly raised event is unmasked |

## Verification
The C1 check assumes that a round-down strobe never arrives in the same cycle as a C1-setting source (qualifier, round-up or overflow), because the block gives the set sources priority. The stimulus drives at most one C1-relevant source per cycle. The stickiness property is checked only in cycles without a clear. The bench toggles `clr_i` as a separate step from the events it wants to see accumulate, except in the one case that tests the priority of clear.

// File: rtl/fpu_exc_status.sv
module fpu_exc_status #(
  parameter int SW_W = 16,
  parameter int NMASK = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic [SW_W-1:0] raise_i,
  input  logic [NMASK-1:0] mask_i,
  input  logic            c1_qual_i,
  input  logic            prec_up_i,
  input  logic            prec_dn_i,
  input  logic            denorm_i,
  input  logic            stk_over_i,
  input  logic            stk_under_i,
  output logic [SW_W-1:0] status_o,
  output logic            unmasked_o
);
  localparam int NFLAG = NMASK + 1;

  logic [NFLAG-1:0] flags_q;
  logic             es_q;
  logic             c1_r;

  wire stk_any = stk_over_i | stk_under_i;
  wire [NFLAG-1:0] ev = raise_i[NFLAG-1:0]
                      | {stk_any, prec_up_i | prec_dn_i, 3'b000, denorm_i, stk_any};
  wire c1_touch = ev[6] | ev[5];
  wire c1_set   = c1_qual_i | prec_up_i | stk_over_i;
  wire [NFLAG-1:0] flags_d = flags_q | ev;
  wire es_d = es_q | (|(flags_d[NMASK-1:0] & ~mask_i));

  assign unmasked_o = |(ev[NMASK-1:0] & ~mask_i);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      flags_q <= '0;
      es_q    <= 1'b0;
      c1_r    <= 1'b0;
    end else begin
      flags_q <= flags_d;
      es_q    <= es_d;
      if (c1_touch) c1_r <= c1_set;
    end
  end

  assign status_o = {es_q, 5'b00000, c1_r, 1'b0, es_q, flags_q};

  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((status_o[6:0] & $past(status_o[6:0])) == $past(status_o[6:0])));
  a_r3_busy_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[15] == status_o[7]);
  a_r4_unmasked_summary: assert property (@(posedge clk) disable iff (!rst_n)
    (unmasked_o && !clr_i) |=> status_o[7]);
  a_r7_round_down: assert property (@(posedge clk) disable iff (!rst_n)
    (prec_dn_i && !prec_up_i && !c1_qual_i && !stk_over_i && !clr_i) |=> !status_o[9]);
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (status_o == '0));
  a_r11_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[8] == 1'b0) && (status_o[14:10] == '0));
endmodule

// File: tb/fpu_exc_status_tb.sv
module fpu_exc_status_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_i = 1'b0;
  logic [15:0] raise_i = '0;
  logic [5:0] mask_i = '1;
  logic c1_qual_i = 1'b0, prec_up_i = 1'b0, prec_dn_i = 1'b0, denorm_i = 1'b0;
  logic stk_over_i = 1'b0, stk_under_i = 1'b0;
  logic [15:0] status_o;
  logic unmasked_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [15:0] exp_q[$];
  string tag_q[$];

  logic [6:0] m_flags = '0;
  logic m_es = 1'b0, m_c1 = 1'b0;

  always #2 clk = ~clk;

  fpu_exc_status u_dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .raise_i(raise_i), .mask_i(mask_i),
    .c1_qual_i(c1_qual_i), .prec_up_i(prec_up_i), .prec_dn_i(prec_dn_i),
    .denorm_i(denorm_i), .stk_over_i(stk_over_i), .stk_under_i(stk_under_i),
    .status_o(status_o), .unmasked_o(unmasked_o)
  );

  task automatic apply(input logic clr, input logic [15:0] rs, input logic [5:0] mk,
                       input logic q, input logic pu, input logic pd, input logic dn,
                       input logic so, input logic su, input string tag);
    logic [6:0] ev;
    logic exp_um;
    @(negedge clk);
    clr_i = clr; raise_i = rs; mask_i = mk; c1_qual_i = q;
    prec_up_i = pu; prec_dn_i = pd; denorm_i = dn; stk_over_i = so; stk_under_i = su;
    ev = rs[6:0];
    ev[0] = ev[0] | so | su;
    ev[6] = ev[6] | so | su;
    ev[5] = ev[5] | pu | pd;
    ev[1] = ev[1] | dn;
    exp_um = |(ev[5:0] & ~mk);
    #1;
    n_chk++;
    if (unmasked_o !== exp_um) begin
      n_bad++;
      $display("FAIL %s unmasked_o actual=%0b expected=%0b", tag, unmasked_o, exp_um);
    end
    if (clr) begin
      m_flags = '0; m_es = 1'b0; m_c1 = 1'b0;
    end else begin
      m_flags = m_flags | ev;
      m_es = m_es | (|(m_flags[5:0] & ~mk));
      if (ev[6] | ev[5]) m_c1 = q | pu | so;
    end
    exp_q.push_back({m_es, 5'b0, m_c1, 1'b0, m_es, m_flags});
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (status_o !== e) begin
        n_bad++;
        $display("FAIL %s status_o actual=%h expected=%h", t, status_o, e);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    n_chk++;
    if (status_o !== 16'h0000) begin
      n_bad++;
      $display("FAIL R11 reset status actual=%h expected=0000", status_o);
    end
    @(negedge clk);
    rst_n = 1'b1;
    apply(0, 16'hFF80, 6'h00, 0, 0, 0, 0, 0, 0, "R1 upper raise bits ignored");
    apply(0, 16'h0004, 6'h3F, 0, 0, 0, 0, 0, 0, "R2 masked ZE sets flag");
    apply(0, 16'h0000, 6'h3F, 0, 0, 0, 0, 0, 0, "R2 flag sticky");
    apply(0, 16'h0000, 6'h3B, 0, 0, 0, 0, 0, 0, "R3 unmask held flag sets summary");
    apply(1, 16'h0000, 6'h3F, 0, 0, 0, 0, 0, 0, "R10 clear");
    apply(0, 16'h0008, 6'h37, 0, 0, 0, 0, 0, 0, "R4 unmasked OE");
    apply(0, 16'h0000, 6'h37, 0, 0, 0, 0, 0, 0, "R4 old flag not unmasked");
    apply(1, 16'h0000, 6'h3F, 0, 0, 0, 0, 0, 0, "R10 clear");
    apply(0, 16'h0000, 6'h3F, 0, 1, 0, 0, 0, 0, "R6 masked round up");
    apply(0, 16'h0000, 6'h3F, 0, 0, 1, 0, 0, 0, "R7 masked round down");
    apply(0, 16'h0040, 6'h3F, 1, 0, 0, 0, 0, 0, "R5 SF with qualifier");
    apply(0, 16'h0001, 6'h3F, 0, 0, 0, 0, 0, 0, "R5 IE leaves C1");
    apply(0, 16'h0020, 6'h3F, 0, 0, 0, 0, 0, 0, "R5 PE no qualifier clears C1");
    apply(1, 16'h0000, 6'h3F, 0, 0, 0, 0, 0, 0, "R10 clear");
    apply(0, 16'h0000, 6'h3F, 0, 0, 0, 1, 0, 0, "R8 masked denormal");
    apply(0, 16'h0000, 6'h3D, 0, 0, 0, 1, 0, 0, "R8 unmasked denormal");
    apply(1, 16'h0000, 6'h3F, 0, 0, 0, 0, 0, 0, "R10 clear");
    apply(0, 16'h0000, 6'h3F, 0, 0, 0, 0, 1, 0, "R9 stack overflow");
    apply(0, 16'h0000, 6'h3F, 0, 0, 0, 0, 0, 1, "R9 stack underflow");
    apply(0, 16'h0000, 6'h3E, 0, 0, 0, 0, 1, 0, "R9 overflow unmasked IE");
    apply(1, 16'h007F, 6'h00, 1, 1, 0, 1, 0, 0, "R10 clear wins over events");
    apply(0, 16'h0000, 6'h1F, 0, 1, 0, 0, 0, 0, "R6 unmasked round up");
    apply(0, 16'h0000, 6'h1F, 0, 0, 0, 0, 0, 0, "R11 idle");
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule